// File: doc/BRIEF.md
# Coprocessor interrupt qualification unit

This block holds the Status and Cause registers of a processor control coprocessor. On every clock it decides whether a hardware interrupt should be taken and presents that decision on a registered `take_irq` output. Software updates the registers through a single-cycle write port. The block also samples the external pending lines into Cause.

The pending test has two schemes, chosen by the `ext_mode` input:

- **Per-line mode** (`ext_mode` = 0). Six hardware lines and two software bits in the Cause IP field are each gated by their own mask bit in the Status IP field.
- **External-controller mode** (`ext_mode` = 1). An outside controller loads a vector level into the Cause IP field. That level is compared as an unsigned number against the priority level held in the Status IP field.

In both modes a global gate must be open before an interrupt is taken. The gate is formed from interrupt-enable, exception-level, error-level, debug mode and a per-thread interrupt-exempt bit.

Top module: `cop_irq_qual`

## Requirements
- R1: During and directly after reset, `status_q`, `cause_q`, `exempt_q` and `take_irq` are all zero.
- R2: A write with `wr_sel`=0 loads Status. Bit 0 is IE, bit 1 is EXL, bit 2 is ERL and bits 15:8 are the IP mask/level. All other Status bits read as zero.
- R3: When `ext_mode`=0, Cause bits 15:10 take the value of `hw_lines` at each clock edge. Cause bits 9:8 are loaded from `wr_data[9:8]` by a write with `wr_sel`=1.
- R4: When `ext_mode`=1, Cause bits 15:8 take the value of `vec_level` at each clock edge, and writes with `wr_sel`=1 have no effect on them.
- R5: When `ext_mode`=0, an interrupt is pending when the bitwise AND of Cause[15:8] and Status[15:8] is nonzero.
- R6: When `ext_mode`=1, an interrupt is pending when Cause[15:8] is strictly greater than Status[15:8] as unsigned numbers.
- R7: The global gate is open only when IE=1, EXL=0, ERL=0, `debug_mode`=0 and the exempt bit is 0.
- R8: A write with `wr_sel`=2 loads the exempt bit from `wr_data[0]` only when `MT_SUPPORT`=1. Otherwise the exempt bit stays 0.
- R9: `take_irq` is a register. It is 1 in the cycle after one in which both the gate and the pending condition held, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 Status, 1 Cause, 2 thread control |
| wr_data | input | 32 | Write data |
| ext_mode | input | 1 | 1 selects external-controller pending scheme |
| hw_lines | input | 6 | External hardware pending lines |
| vec_level | input | 8 | Vector level from external controller |
| debug_mode | input | 1 | Core is in debug mode |
| status_q | output | 32 | Status register contents |
| cause_q | output | 32 | Cause register contents |
| exempt_q | output | 1 | Per-thread interrupt-exempt bit |
| take_irq | output | 1 | Registered take-interrupt decision |

## Verification
The bench builds two copies of the block side by side. One has `MT_SUPPORT`=1, which allows the exempt bit to be set so that its gating can be checked. The other has `MT_SUPPORT`=0, which shows that the same write leaves the bit at zero and leaves interrupts flowing. Both copies keep the default 8-bit IP field.

The bench includes pending/mask pairs such as 4 against 3 and 1 against 3. For these pairs the AND test and the magnitude compare give opposite answers, so a swapped or merged mode decode is exposed.

// File: rtl/cop_irq_qual.sv
module cop_irq_qual #(
  parameter bit MT_SUPPORT = 1'b1,
  parameter int IP_W       = 8,
  parameter int IP_LSB     = 8,
  parameter int REG_W      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               ext_mode,
  input  logic [IP_W-3:0]    hw_lines,
  input  logic [IP_W-1:0]    vec_level,
  input  logic               debug_mode,
  output logic [REG_W-1:0]   status_q,
  output logic [REG_W-1:0]   cause_q,
  output logic               exempt_q,
  output logic               take_irq
);
  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_CAUSE  = 2'd1;
  localparam logic [1:0] SEL_THREAD = 2'd2;

  logic            st_ie, st_exl, st_erl;
  logic [IP_W-1:0] st_ip, ca_ip;
  logic            glob_en, pend_line, pend_vec, pend;
  logic            unused_wr;

  assign unused_wr = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_ie    <= 1'b0;
      st_exl   <= 1'b0;
      st_erl   <= 1'b0;
      st_ip    <= '0;
      ca_ip    <= '0;
      exempt_q <= 1'b0;
      take_irq <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_STATUS) begin
        st_ie  <= wr_data[0];
        st_exl <= wr_data[1];
        st_erl <= wr_data[2];
        st_ip  <= wr_data[IP_LSB +: IP_W];
      end
      if (ext_mode) begin
        ca_ip <= vec_level;
      end else begin
        ca_ip[IP_W-1:2] <= hw_lines;
        if (wr_en && wr_sel == SEL_CAUSE)
          ca_ip[1:0] <= wr_data[IP_LSB +: 2];
      end
      if (wr_en && wr_sel == SEL_THREAD)
        exempt_q <= MT_SUPPORT & wr_data[0];
      take_irq <= glob_en & pend;
    end
  end

  assign glob_en   = st_ie & ~st_exl & ~st_erl & ~debug_mode & ~exempt_q;
  assign pend_line = |(ca_ip & st_ip);
  assign pend_vec  = ca_ip > st_ip;
  assign pend      = ext_mode ? pend_vec : pend_line;

  always_comb begin
    status_q = '0;
    status_q[IP_LSB +: IP_W] = st_ip;
    status_q[2:0] = {st_erl, st_exl, st_ie};
    cause_q = '0;
    cause_q[IP_LSB +: IP_W] = ca_ip;
  end
endmodule

// File: rtl/cop_irq_qual_chk.sv
module cop_irq_qual_chk #(
  parameter int IP_W   = 8,
  parameter int IP_LSB = 8,
  parameter int REG_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_mode,
  input logic [IP_W-3:0]  hw_lines,
  input logic [IP_W-1:0]  vec_level,
  input logic             debug_mode,
  input logic [REG_W-1:0] status_q,
  input logic [REG_W-1:0] cause_q,
  input logic             exempt_q,
  input logic             take_irq
);
  a_r9_take_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> ($past(status_q[0]) && !$past(status_q[1]) && !$past(status_q[2])
                  && !$past(debug_mode) && !$past(exempt_q)));

  a_r7_exempt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(exempt_q)) |-> !take_irq);

  a_r3_hw_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ext_mode)) |-> cause_q[IP_LSB+2 +: IP_W-2] == $past(hw_lines));

  a_r4_vec_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ext_mode)) |-> cause_q[IP_LSB +: IP_W] == $past(vec_level));

  a_r6_vec_compare: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ext_mode) && take_irq)
      |-> $past(cause_q[IP_LSB +: IP_W]) > $past(status_q[IP_LSB +: IP_W]));
endmodule

bind cop_irq_qual cop_irq_qual_chk #(.IP_W(IP_W), .IP_LSB(IP_LSB), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .hw_lines(hw_lines),
  .vec_level(vec_level), .debug_mode(debug_mode), .status_q(status_q),
  .cause_q(cause_q), .exempt_q(exempt_q), .take_irq(take_irq)
);

// File: tb/cop_irq_qual_tb.sv
`timescale 1ns/1ps
module cop_irq_qual_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        ext_mode = 1'b0;
  logic [5:0]  hw_lines = '0;
  logic [7:0]  vec_level = '0;
  logic        debug_mode = 1'b0;
  logic [31:0] status_q, cause_q, status_n, cause_n;
  logic        exempt_q, take_irq, exempt_n, take_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cop_irq_qual #(.MT_SUPPORT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_mode(ext_mode), .hw_lines(hw_lines), .vec_level(vec_level),
    .debug_mode(debug_mode), .status_q(status_q), .cause_q(cause_q),
    .exempt_q(exempt_q), .take_irq(take_irq));

  cop_irq_qual #(.MT_SUPPORT(1'b0)) u_nomt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_mode(ext_mode), .hw_lines(hw_lines), .vec_level(vec_level),
    .debug_mode(debug_mode), .status_q(status_n), .cause_q(cause_n),
    .exempt_q(exempt_n), .take_irq(take_n));

  // {mode, hw[5:0], sw[1:0], vlevel[7:0], mask[7:0], expected take}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 6'h00, 2'd0, 8'h00, 8'hFF, 1'b0},
    {1'b0, 6'h01, 2'd0, 8'h00, 8'h04, 1'b1},
    {1'b0, 6'h20, 2'd0, 8'h00, 8'h7F, 1'b0},
    {1'b0, 6'h00, 2'd2, 8'h00, 8'h02, 1'b1},
    {1'b0, 6'h01, 2'd0, 8'h00, 8'h03, 1'b0},
    {1'b1, 6'h00, 2'd3, 8'h04, 8'h03, 1'b1},
    {1'b0, 6'h00, 2'd1, 8'h00, 8'h03, 1'b1},
    {1'b1, 6'h00, 2'd3, 8'h01, 8'h03, 1'b0},
    {1'b1, 6'h00, 2'd3, 8'h80, 8'h7F, 1'b1},
    {1'b1, 6'h00, 2'd3, 8'h05, 8'h05, 1'b0},
    {1'b1, 6'h00, 2'd3, 8'hFF, 8'hFE, 1'b1},
    {1'b1, 6'h00, 2'd3, 8'h00, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status in reset", status_q, 32'h0);
    chk("R1 take in reset", {31'b0, take_irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cause after reset", cause_q, 32'h0);
    chk("R1 exempt after reset", {31'b0, exempt_q}, 32'h0);
    chk("R1 take after reset", {31'b0, take_irq}, 32'h0);

    wr(2'd0, 32'hFFFF_FFFF);
    chk("R2 status field mask", status_q, 32'h0000_FF07);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      logic [7:0]  exp_ip;
      v = VEC[i];
      @(negedge clk);
      ext_mode = v[25]; hw_lines = v[24:19]; vec_level = v[16:9];
      wr(2'd0, {16'h0, v[8:1], 8'h01});
      wr(2'd1, {22'h0, v[18:17], 8'h00});
      settle();
      exp_ip = v[25] ? v[16:9] : {v[24:19], v[18:17]};
      chk(v[25] ? "R4 cause from vector level" : "R3 cause from lines and sw bits",
          cause_q, {16'h0, exp_ip, 8'h00});
      chk(v[25] ? "R6 magnitude pending" : "R5 masked pending",
          {31'b0, take_irq}, {31'b0, v[0]});
    end

    ext_mode = 1'b0; hw_lines = 6'h3F;
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h0000_FF00);
    settle();
    chk("R7 IE clear blocks", {31'b0, take_irq}, 32'h0);
    wr(2'd0, 32'h0000_FF01);
    chk("R9 take not yet registered", {31'b0, take_irq}, 32'h0);
    @(negedge clk);
    chk("R9 take one cycle later", {31'b0, take_irq}, 32'h1);
    wr(2'd0, 32'h0000_FF03);
    settle();
    chk("R7 EXL blocks", {31'b0, take_irq}, 32'h0);
    wr(2'd0, 32'h0000_FF05);
    settle();
    chk("R7 ERL blocks", {31'b0, take_irq}, 32'h0);
    wr(2'd0, 32'h0000_FF01);
    debug_mode = 1'b1;
    settle();
    chk("R7 debug blocks", {31'b0, take_irq}, 32'h0);
    debug_mode = 1'b0;
    settle();
    chk("R7 debug released", {31'b0, take_irq}, 32'h1);
    wr(2'd2, 32'h1);
    chk("R8 exempt set with MT", {31'b0, exempt_q}, 32'h1);
    chk("R8 exempt stays 0 without MT", {31'b0, exempt_n}, 32'h0);
    settle();
    chk("R7 exempt blocks", {31'b0, take_irq}, 32'h0);
    chk("R8 no-MT copy still takes", {31'b0, take_n}, 32'h1);
    wr(2'd2, 32'h0);
    settle();
    chk("R7 exempt cleared", {31'b0, take_irq}, 32'h1);

    ext_mode = 1'b1; vec_level = 8'h10;
    wr(2'd0, 32'h0000_2001);
    settle();
    chk("R6 level below mask", {31'b0, take_irq}, 32'h0);
    wr(2'd1, 32'h0000_FF00);
    chk("R4 cause write ignored", cause_q, 32'h0000_1000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule